// File: doc/BRIEF.md
# Load Dependence Chain Tracker

This block follows, for every architectural register, which recent load produced the register's current value. Each retired instruction is presented once, with its class, its destination and source register numbers and its PC. A load stamps its destination with its own PC and the current retirement time. A constant-producing instruction clears the destination. A two-source ALU instruction passes the load ancestry of its sources on to its destination.

Each register entry holds two chain slots. The young slot names the most recent load that fed the value. The alternate slot names the next older distinct load, so that a later consumer has a fallback producer. A consumer load presents its address register on the query port. It reads both slots combinationally: a valid flag, the producer PC and the producer timestamp for each. A free-running 32-bit retirement counter supplies the timestamps.

Top module: `ldchain_tracker`

## Requirements
- R1: After reset every register reads with both slots invalid, and the retirement time `now_ts` reads 0.
- R2: A retired load (`ret_cls` = 1) writes its destination with a valid young slot holding `ret_pc` and the value `now_ts` had in that cycle, and writes the alternate slot invalid. The new contents are visible on the query port from the next cycle.
- R3: A retired constant-producing instruction (`ret_cls` = 2) writes both slots of its destination invalid.
- R4: A retired ALU instruction (`ret_cls` = 3) writes, as its destination's young slot, the valid slot with the largest timestamp among the four slots of its two sources.
- R5: An invalid slot never wins the age selection. If all four source slots are invalid, both destination slots are written invalid.
- R6: The alternate slot written by an ALU instruction is the valid source slot with the largest timestamp strictly below the new young timestamp. It is invalid when no such slot exists. A valid alternate always has a smaller timestamp than its young slot.
- R7: `now_ts` increments by one on each cycle where `ret_valid` is 1 and `ret_cls` is not 0. A cycle with `ret_valid` at 0, or with `ret_cls` = 0, changes neither the table nor `now_ts`.
- R8: When the queried register is written in the same cycle, the query port shows the contents from before that write.
- R9: A retirement changes only the entry of its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | A retired instruction is presented this cycle |
| ret_cls | input | 2 | Class: 0 none, 1 load, 2 constant, 3 two-source ALU |
| ret_dst | input | REG_W | Destination register number |
| ret_src1 | input | REG_W | First source register number (ALU) |
| ret_src2 | input | REG_W | Second source register number (ALU) |
| ret_pc | input | PC_W | PC of the retired instruction |
| qry_reg | input | REG_W | Address register of the consumer load being looked up |
| qry_yng_vld | output | 1 | Young slot of the queried register is valid |
| qry_yng_pc | output | PC_W | Producer PC in the young slot |
| qry_yng_ts | output | 32 | Producer timestamp in the young slot |
| qry_alt_vld | output | 1 | Alternate slot of the queried register is valid |
| qry_alt_pc | output | PC_W | Producer PC in the alternate slot |
| qry_alt_ts | output | 32 | Producer timestamp in the alternate slot |
| now_ts | output | 32 | Current retirement time |

## Verification
A lookup and a table write can fall in the same cycle, and they can target the same register. An ALU instruction can also read its own destination as a source in the cycle it overwrites it. The bench retires a load into the register it is querying and checks the port before the clock edge, expecting the old chain, and again after the edge, expecting the new one. Long pseudo-random retirement streams whose ALU operations reuse their destination as a source are judged against a register model in the bench that reads the sources' old contents before it writes.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    localparam int LDC_TS_W = 32;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_CONST = 2'd2,
        CLS_ALU   = 2'd3
    } ret_cls_e;

    // a is preferred over b when a is valid and b is either invalid or older
    function automatic logic slot_beats(input logic                av,
                                        input logic [LDC_TS_W-1:0] at,
                                        input logic                bv,
                                        input logic [LDC_TS_W-1:0] bt);
        return av && (!bv || (at > bt));
    endfunction

endpackage

// File: rtl/ldc_timer.sv
module ldc_timer
    import ldc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    output logic [LDC_TS_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (tick) begin
            now <= now + 1'b1;
        end
    end

endmodule

// File: rtl/ldc_select.sv
module ldc_select
    import ldc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int NCAND = 4
) (
    input  logic                vld_i [NCAND],
    input  logic [PC_W-1:0]     pc_i  [NCAND],
    input  logic [LDC_TS_W-1:0] ts_i  [NCAND],
    output logic                yng_vld,
    output logic [PC_W-1:0]     yng_pc,
    output logic [LDC_TS_W-1:0] yng_ts,
    output logic                alt_vld,
    output logic [PC_W-1:0]     alt_pc,
    output logic [LDC_TS_W-1:0] alt_ts
);

    // youngest valid candidate
    always_comb begin
        yng_vld = 1'b0;
        yng_pc  = '0;
        yng_ts  = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (slot_beats(vld_i[i], ts_i[i], yng_vld, yng_ts)) begin
                yng_vld = 1'b1;
                yng_pc  = pc_i[i];
                yng_ts  = ts_i[i];
            end
        end
    end

    // youngest valid candidate strictly older than the winner
    always_comb begin
        alt_vld = 1'b0;
        alt_pc  = '0;
        alt_ts  = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (yng_vld && vld_i[i] && (ts_i[i] < yng_ts) &&
                slot_beats(vld_i[i], ts_i[i], alt_vld, alt_ts)) begin
                alt_vld = 1'b1;
                alt_pc  = pc_i[i];
                alt_ts  = ts_i[i];
            end
        end
    end

endmodule

// File: rtl/ldc_table.sv
module ldc_table
    import ldc_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int PC_W  = 16,
    localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int SLOT_W = 1 + PC_W + LDC_TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] wr_yng,
    input  logic [SLOT_W-1:0] wr_alt,
    input  logic [REG_W-1:0]  a_idx,
    input  logic [REG_W-1:0]  b_idx,
    input  logic [REG_W-1:0]  q_idx,
    output logic [SLOT_W-1:0] a_yng,
    output logic [SLOT_W-1:0] a_alt,
    output logic [SLOT_W-1:0] b_yng,
    output logic [SLOT_W-1:0] b_alt,
    output logic [SLOT_W-1:0] q_yng,
    output logic [SLOT_W-1:0] q_alt
);

    logic [SLOT_W-1:0] yng_q [NREG];
    logic [SLOT_W-1:0] alt_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                yng_q[r] <= '0;
                alt_q[r] <= '0;
            end else if (wr_en && (wr_idx == REG_W'(r))) begin
                yng_q[r] <= wr_yng;
                alt_q[r] <= wr_alt;
            end
        end
    end

    assign a_yng = yng_q[a_idx];
    assign a_alt = alt_q[a_idx];
    assign b_yng = yng_q[b_idx];
    assign b_alt = alt_q[b_idx];
    assign q_yng = yng_q[q_idx];
    assign q_alt = alt_q[q_idx];

endmodule

// File: rtl/ldchain_tracker.sv
module ldchain_tracker
    import ldc_pkg::*;
#(
    parameter int NREG = 32,
    parameter int PC_W = 16,
    localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ret_valid,
    input  logic [1:0]          ret_cls,
    input  logic [REG_W-1:0]    ret_dst,
    input  logic [REG_W-1:0]    ret_src1,
    input  logic [REG_W-1:0]    ret_src2,
    input  logic [PC_W-1:0]     ret_pc,
    input  logic [REG_W-1:0]    qry_reg,
    output logic                qry_yng_vld,
    output logic [PC_W-1:0]     qry_yng_pc,
    output logic [LDC_TS_W-1:0] qry_yng_ts,
    output logic                qry_alt_vld,
    output logic [PC_W-1:0]     qry_alt_pc,
    output logic [LDC_TS_W-1:0] qry_alt_ts,
    output logic [LDC_TS_W-1:0] now_ts
);

    localparam int NCAND = 4;

    typedef struct packed {
        logic                vld;
        logic [PC_W-1:0]     pc;
        logic [LDC_TS_W-1:0] ts;
    } slot_t;

    ret_cls_e cls;
    logic     wr_en;
    slot_t    src1_yng, src1_alt, src2_yng, src2_alt;
    slot_t    q_yng, q_alt;
    slot_t    new_yng, new_alt;
    slot_t    sel_yng, sel_alt;

    logic                c_vld [NCAND];
    logic [PC_W-1:0]     c_pc  [NCAND];
    logic [LDC_TS_W-1:0] c_ts  [NCAND];

    assign cls   = ret_cls_e'(ret_cls);
    assign wr_en = ret_valid && (cls != CLS_NONE);

    ldc_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (wr_en),
        .now  (now_ts)
    );

    ldc_table #(.NREG(NREG), .PC_W(PC_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (ret_dst),
        .wr_yng (new_yng),
        .wr_alt (new_alt),
        .a_idx  (ret_src1),
        .b_idx  (ret_src2),
        .q_idx  (qry_reg),
        .a_yng  (src1_yng),
        .a_alt  (src1_alt),
        .b_yng  (src2_yng),
        .b_alt  (src2_alt),
        .q_yng  (q_yng),
        .q_alt  (q_alt)
    );

    always_comb begin
        slot_t cands [NCAND];
        cands[0] = src1_yng;
        cands[1] = src1_alt;
        cands[2] = src2_yng;
        cands[3] = src2_alt;
        for (int i = 0; i < NCAND; i++) begin
            c_vld[i] = cands[i].vld;
            c_pc[i]  = cands[i].pc;
            c_ts[i]  = cands[i].ts;
        end
    end

    ldc_select #(.PC_W(PC_W), .NCAND(NCAND)) u_select (
        .vld_i   (c_vld),
        .pc_i    (c_pc),
        .ts_i    (c_ts),
        .yng_vld (sel_yng.vld),
        .yng_pc  (sel_yng.pc),
        .yng_ts  (sel_yng.ts),
        .alt_vld (sel_alt.vld),
        .alt_pc  (sel_alt.pc),
        .alt_ts  (sel_alt.ts)
    );

    always_comb begin
        new_yng = '0;
        new_alt = '0;
        unique case (cls)
            CLS_LOAD: begin
                new_yng.vld = 1'b1;
                new_yng.pc  = ret_pc;
                new_yng.ts  = now_ts;
            end
            CLS_ALU: begin
                new_yng = sel_yng;
                new_alt = sel_alt;
            end
            default: begin
                new_yng = '0;
                new_alt = '0;
            end
        endcase
    end

    assign qry_yng_vld = q_yng.vld;
    assign qry_yng_pc  = q_yng.pc;
    assign qry_yng_ts  = q_yng.ts;
    assign qry_alt_vld = q_alt.vld;
    assign qry_alt_pc  = q_alt.pc;
    assign qry_alt_ts  = q_alt.ts;

endmodule

// File: rtl/ldc_checker.sv
module ldc_checker
    import ldc_pkg::*;
#(
    parameter int NREG = 32,
    parameter int PC_W = 16,
    localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                ret_valid,
    input logic [1:0]          ret_cls,
    input logic [REG_W-1:0]    ret_dst,
    input logic [REG_W-1:0]    ret_src1,
    input logic [REG_W-1:0]    ret_src2,
    input logic [PC_W-1:0]     ret_pc,
    input logic [REG_W-1:0]    qry_reg,
    input logic                qry_yng_vld,
    input logic [PC_W-1:0]     qry_yng_pc,
    input logic [LDC_TS_W-1:0] qry_yng_ts,
    input logic                qry_alt_vld,
    input logic [PC_W-1:0]     qry_alt_pc,
    input logic [LDC_TS_W-1:0] qry_alt_ts,
    input logic [LDC_TS_W-1:0] now_ts
);

    logic unused_ok;
    assign unused_ok = ^{ret_src1, ret_src2, qry_alt_pc};

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!qry_yng_vld && !qry_alt_vld && (now_ts == '0)));

    a_r7_time_tick: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && (ret_cls != 2'd0)) |=> (now_ts == $past(now_ts) + 1'b1));

    a_r7_time_hold: assert property (@(posedge clk) disable iff (rst)
        !(ret_valid && (ret_cls != 2'd0)) |=> $stable(now_ts));

    a_r2_load_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ret_valid) && ($past(ret_cls) == 2'd1) &&
         (qry_reg == $past(ret_dst)))
        |-> (qry_yng_vld && (qry_yng_pc == $past(ret_pc)) &&
             (qry_yng_ts == $past(now_ts)) && !qry_alt_vld));

    a_r3_const_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ret_valid) && ($past(ret_cls) == 2'd2) &&
         (qry_reg == $past(ret_dst)))
        |-> (!qry_yng_vld && !qry_alt_vld));

    a_r6_alt_older: assert property (@(posedge clk) disable iff (rst)
        qry_alt_vld |-> (qry_yng_vld && (qry_alt_ts < qry_yng_ts)));

    a_r2_stamp_past: assert property (@(posedge clk) disable iff (rst)
        qry_yng_vld |-> (qry_yng_ts < now_ts));

endmodule

bind ldchain_tracker ldc_checker #(.NREG(NREG), .PC_W(PC_W)) u_chk (.*);

// File: tb/ldchain_tracker_tb.sv
module ldchain_tracker_tb;

    localparam int NREG  = 4;
    localparam int PC_W  = 8;
    localparam int REG_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ret_valid = 1'b0;
    logic [1:0]       ret_cls = 2'd0;
    logic [REG_W-1:0] ret_dst = '0;
    logic [REG_W-1:0] ret_src1 = '0;
    logic [REG_W-1:0] ret_src2 = '0;
    logic [PC_W-1:0]  ret_pc = '0;
    logic [REG_W-1:0] qry_reg = '0;
    logic             qry_yng_vld, qry_alt_vld;
    logic [PC_W-1:0]  qry_yng_pc, qry_alt_pc;
    logic [31:0]      qry_yng_ts, qry_alt_ts, now_ts;

    ldchain_tracker #(.NREG(NREG), .PC_W(PC_W)) u_dut (.*);

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the table
    logic        m_yv [NREG];
    logic [7:0]  m_yp [NREG];
    logic [31:0] m_yt [NREG];
    logic        m_av [NREG];
    logic [7:0]  m_ap [NREG];
    logic [31:0] m_at [NREG];
    logic [31:0] m_now;

    task automatic model_reset();
        for (int r = 0; r < NREG; r++) begin
            m_yv[r] = 0; m_yp[r] = 0; m_yt[r] = 0;
            m_av[r] = 0; m_ap[r] = 0; m_at[r] = 0;
        end
        m_now = 0;
    endtask

    task automatic model_apply(input bit v, input int cls, input int d,
                               input int s1, input int s2, input logic [7:0] pc);
        logic        cv [4];
        logic [7:0]  cp [4];
        logic [31:0] ct [4];
        logic        yv, av;
        logic [7:0]  yp, ap;
        logic [31:0] yt, at;
        if (!v || cls == 0) return;
        yv = 0; yp = 0; yt = 0; av = 0; ap = 0; at = 0;
        if (cls == 1) begin
            yv = 1; yp = pc; yt = m_now;
        end else if (cls == 3) begin
            cv[0] = m_yv[s1]; cp[0] = m_yp[s1]; ct[0] = m_yt[s1];
            cv[1] = m_av[s1]; cp[1] = m_ap[s1]; ct[1] = m_at[s1];
            cv[2] = m_yv[s2]; cp[2] = m_yp[s2]; ct[2] = m_yt[s2];
            cv[3] = m_av[s2]; cp[3] = m_ap[s2]; ct[3] = m_at[s2];
            for (int k = 0; k < 4; k++)
                if (cv[k] && (!yv || ct[k] > yt)) begin yv = 1; yp = cp[k]; yt = ct[k]; end
            for (int k = 0; k < 4; k++)
                if (yv && cv[k] && ct[k] < yt && (!av || ct[k] > at)) begin
                    av = 1; ap = cp[k]; at = ct[k];
                end
        end
        m_yv[d] = yv; m_yp[d] = yp; m_yt[d] = yt;
        m_av[d] = av; m_ap[d] = ap; m_at[d] = at;
        m_now = m_now + 1;
    endtask

    task automatic check_reg(input int r, input string tag);
        logic [81:0] act, exp;
        qry_reg = REG_W'(r);
        #1;
        act = {qry_yng_vld, qry_yng_vld ? qry_yng_pc : 8'd0, qry_yng_vld ? qry_yng_ts : 32'd0,
               qry_alt_vld, qry_alt_vld ? qry_alt_pc : 8'd0, qry_alt_vld ? qry_alt_ts : 32'd0};
        exp = {m_yv[r], m_yp[r], m_yt[r], m_av[r], m_ap[r], m_at[r]};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s reg %0d: actual %h expected %h", tag, r, act, exp);
        end
    endtask

    task automatic check_now(input string tag);
        n_chk++;
        if (now_ts !== m_now) begin
            n_fail++;
            $display("FAIL %s now_ts: actual %0d expected %0d", tag, now_ts, m_now);
        end
    endtask

    // drive at a falling edge, let one rising edge take it, drop valid
    task automatic retire(input bit v, input int cls, input int d,
                          input int s1, input int s2, input logic [7:0] pc);
        @(negedge clk);
        ret_valid = v; ret_cls = 2'(cls); ret_dst = REG_W'(d);
        ret_src1 = REG_W'(s1); ret_src2 = REG_W'(s2); ret_pc = pc;
        model_apply(v, cls, d, s1, s2, pc);
        @(negedge clk);
        ret_valid = 0;
    endtask

    task automatic check_all(input int d, input string dtag);
        check_now("R7");
        for (int r = 0; r < NREG; r++) check_reg(r, (r == d) ? dtag : "R9");
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        int cls, d, s1, s2;
        bit v;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: all clear after reset
        check_all(0, "R1");

        // R2: load pc 0x11 into r1 at time 0
        retire(1, 1, 1, 0, 0, 8'h11);
        check_all(1, "R2");
        // R2: load pc 0x22 into r2 at time 1
        retire(1, 1, 2, 0, 0, 8'h22);
        check_all(2, "R2");
        // R4/R6: r3 = r1 op r2 -> young 0x22@1, alt 0x11@0
        retire(1, 3, 3, 1, 2, 8'h33);
        check_all(3, "R4");
        check_reg(3, "R6");
        // R3: constant into r0
        retire(1, 2, 0, 0, 0, 8'h44);
        check_all(0, "R3");
        // R5: r0 = r0 op r0, all inputs invalid -> both invalid
        retire(1, 3, 0, 0, 0, 8'h55);
        check_all(0, "R5");
        // R5: r1 = r0 op r3, invalid side loses -> young 0x22, alt 0x11
        retire(1, 3, 1, 0, 3, 8'h66);
        check_all(1, "R5");
        // R6: r2 = r2 op r2, one chain duplicated -> alt invalid
        retire(1, 3, 2, 2, 2, 8'h77);
        check_all(2, "R6");
        // R7: load with valid low and class none both ignored
        retire(0, 1, 0, 0, 0, 8'h88);
        check_all(0, "R7");
        retire(1, 0, 3, 0, 0, 8'h99);
        check_all(3, "R7");

        // R8: query r3 while a load overwrites it
        @(negedge clk);
        ret_valid = 1; ret_cls = 2'd1; ret_dst = 2'd3; ret_pc = 8'hAB;
        check_reg(3, "R8");
        model_apply(1, 1, 3, 0, 0, 8'hAB);
        @(negedge clk);
        ret_valid = 0;
        check_reg(3, "R8");

        // sweep of pseudo-random retirement streams
        lcg = 32'h1234_5677;
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            v   = (lcg[31:28] != 4'd0);
            cls = (lcg[27:25] == 3'd0) ? 0 : ((lcg[24:23] == 2'd0) ? 2 :
                  (lcg[22] ? 3 : 1));
            d   = int'(lcg[21:20]);
            s1  = int'(lcg[19:18]);
            s2  = lcg[17] ? d : int'(lcg[16:15]);
            retire(v, cls, d, s1, s2, lcg[14:7]);
            check_all(d, (!v || cls == 0) ? "R7" : (cls == 1) ? "R2" :
                         (cls == 2) ? "R3" : "R4");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule